// File: doc/BRIEF.md
# Virtqueue Common Configuration Register File

This block is the register file that a paravirtual PCI function shows to its driver for device-wide setup and per-queue setup. The device-wide part holds two 64-bit feature sets seen through 32-bit windows. One is the set the device offers, which is fixed by a parameter. The other is the set the driver acknowledges. The device-wide part also holds a configuration interrupt vector, the queue count and a device status byte. The per-queue part holds a ring size, an interrupt vector, an enable bit, a notify offset and three 64-bit ring addresses. A queue selector register chooses which queue this whole set refers to.

The driver reaches the registers over a simple 32-bit register bus. Each access carries a byte address, four byte enables, and a write or read strobe. Read data returns one cycle after the strobe, together with a valid flag. Every queue's state and the acknowledged feature set are driven continuously to the device core. The core uses the per-queue active flag to decide whether it may process a queue.

Top module: `vq_cfg_regs`

## Requirements
- R1: After reset, device status reads 0, both feature selects read 0, the driver feature set is 0, and the configuration vector reads 0xFFFF. Every queue has size MAX_QSIZE, vector 0xFFFF, enable 0 and all ring addresses 0. The queue count (offset 18, lanes 2-3) reads NUM_Q.
- R2: The offered features are read at offset 4 and their select is at offset 0. Select 0 returns bits 31:0 and select 1 returns bits 63:32. Any other select value returns 0.
- R3: The acknowledged features are at offset 12 and their select is at offset 8. Select 0 maps to bits 31:0 and select 1 maps to bits 63:32. With any other select value, a write there leaves drv_feat_o unchanged and a read returns 0.
- R4: Writes to the offered feature word (offset 4), the queue count (offset 18) and the notify offset (offset 30, lanes 2-3) have no effect. The notify offset reads back as the selected queue's index.
- R5: A queue size write (offset 24, lanes 0-1) is taken only if the value is 0 or a power of two no larger than MAX_QSIZE. Otherwise the old size is kept.
- R6: A vector write is stored as written if the value is below VEC_TABLE. Otherwise it is stored as 0xFFFF. This applies to the configuration vector (offset 16, lanes 0-1) and to the queue vector (offset 26, lanes 2-3).
- R7: The queue select register (offset 22, lanes 2-3) chooses which queue's set the per-queue offsets (24 to 55) read and write. Other queues are left untouched. Queue enable is at offset 28, lanes 0-1, bit 0.
- R8: While queue select is NUM_Q or more, per-queue offsets read 0 and writes to them change no queue.
- R9: A write of 0 to device status (offset 20, lane 0) restores every queue to its reset values and clears both feature selects and the queue select. A nonzero status write is stored and appears on dev_status_o.
- R10: An access with bus_addr[1:0] nonzero, a byte-enable pattern other than the field's own lanes, the reserved byte at offset 21, or an offset of 56 or above reads 0 and writes nothing.
- R11: q_active_o for a queue is 1 exactly when its enable is 1 and its size is nonzero.
- R12: Each 64-bit ring address is two 32-bit halves, low half first. Descriptor is at 32/36, available ring at 40/44 and used ring at 48/52.
- R13: A read strobe in one cycle gives bus_rvalid high with the data in the next cycle only. Bytes are placed little-endian: a field at byte offset 2 within its 32-bit word sits in bits 31:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the 32-bit word accessed |
| bus_be | input | 4 | Byte lane enables |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| drv_feat_o | output | 64 | Driver-acknowledged feature set |
| dev_status_o | output | 8 | Device status byte |
| cfg_vec_o | output | 16 | Configuration change interrupt vector |
| q_size_o | output | NUM_Q*16 | Ring size of each queue |
| q_vec_o | output | NUM_Q*16 | Interrupt vector of each queue |
| q_en_o | output | NUM_Q | Enable of each queue |
| q_active_o | output | NUM_Q | Queue may be processed |
| q_desc_o | output | NUM_Q*64 | Descriptor table address of each queue |
| q_avail_o | output | NUM_Q*64 | Available ring address of each queue |
| q_used_o | output | NUM_Q*64 | Used ring address of each queue |

## Verification
Every queue's stored state is driven continuously on the core-facing outputs. A write that lands in the wrong bank, or one that should have been dropped, therefore shows on those outputs at the first edge after the strobe, and the bench compares them on every clock. State that the outputs do not show is the feature selects, the queue select and the read mux. A fault there shows only on the next read, one cycle after its strobe, so each write that matters is followed by a read of the register it touched or of the window it chose.

// File: rtl/vq_cfg_pkg.sv
package vq_cfg_pkg;

  typedef enum logic [4:0] {
    FLD_NONE, FLD_DFSEL, FLD_DFEAT, FLD_GFSEL, FLD_GFEAT,
    FLD_CFGVEC, FLD_NUMQ, FLD_STATUS, FLD_QSEL,
    FLD_QSIZE, FLD_QVEC, FLD_QEN, FLD_QNOFF,
    FLD_DESC_LO, FLD_DESC_HI, FLD_AVL_LO, FLD_AVL_HI, FLD_USED_LO, FLD_USED_HI
  } fld_e;

  localparam logic [15:0] NO_VECTOR = 16'hFFFF;

  // ring size legal: zero or a power of two, not above the device maximum
  function automatic logic size_ok(input logic [15:0] v, input int unsigned max_sz);
    return ((v & (v - 16'd1)) == 16'd0) && ({16'd0, v} <= max_sz);
  endfunction

  // vector mapping: entries inside the table are kept, all else becomes NO_VECTOR
  function automatic logic [15:0] vec_map(input logic [15:0] v, input int unsigned tbl);
    return ({16'd0, v} < tbl) ? v : NO_VECTOR;
  endfunction

  // 32-bit window onto a 64-bit feature set
  function automatic logic [31:0] feat_window(input logic [63:0] f, input logic [31:0] sel);
    case (sel)
      32'd0:   return f[31:0];
      32'd1:   return f[63:32];
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic is_queue_fld(input fld_e f);
    return f inside {FLD_QSIZE, FLD_QVEC, FLD_QEN, FLD_QNOFF, FLD_DESC_LO,
                     FLD_DESC_HI, FLD_AVL_LO, FLD_AVL_HI, FLD_USED_LO, FLD_USED_HI};
  endfunction

endpackage

// File: rtl/vq_cfg_decode.sv
module vq_cfg_decode
  import vq_cfg_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  output fld_e              fld_o
);

  logic [ADDR_W-3:0] dw;
  assign dw = addr_i[ADDR_W-1:2];

  // only an aligned word with exactly the field's own lanes is a match
  always_comb begin
    fld_o = FLD_NONE;
    if (addr_i[1:0] == 2'b00) begin
      case (int'(dw))
        0:  if (be_i == 4'hF) fld_o = FLD_DFSEL;
        1:  if (be_i == 4'hF) fld_o = FLD_DFEAT;
        2:  if (be_i == 4'hF) fld_o = FLD_GFSEL;
        3:  if (be_i == 4'hF) fld_o = FLD_GFEAT;
        4:  if (be_i == 4'h3) fld_o = FLD_CFGVEC;
            else if (be_i == 4'hC) fld_o = FLD_NUMQ;
        5:  if (be_i == 4'h1) fld_o = FLD_STATUS;
            else if (be_i == 4'hC) fld_o = FLD_QSEL;
        6:  if (be_i == 4'h3) fld_o = FLD_QSIZE;
            else if (be_i == 4'hC) fld_o = FLD_QVEC;
        7:  if (be_i == 4'h3) fld_o = FLD_QEN;
            else if (be_i == 4'hC) fld_o = FLD_QNOFF;
        8:  if (be_i == 4'hF) fld_o = FLD_DESC_LO;
        9:  if (be_i == 4'hF) fld_o = FLD_DESC_HI;
        10: if (be_i == 4'hF) fld_o = FLD_AVL_LO;
        11: if (be_i == 4'hF) fld_o = FLD_AVL_HI;
        12: if (be_i == 4'hF) fld_o = FLD_USED_LO;
        13: if (be_i == 4'hF) fld_o = FLD_USED_HI;
        default: fld_o = FLD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/vq_cfg_qslot.sv
module vq_cfg_qslot
  import vq_cfg_pkg::*;
#(
  parameter int unsigned MAX_QSIZE = 256,
  parameter int unsigned VEC_TABLE = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr_i,
  input  logic        wr_i,
  input  fld_e        fld_i,
  input  logic [31:0] wdata_i,
  output logic [15:0] size_o,
  output logic [15:0] vec_o,
  output logic        en_o,
  output logic [63:0] desc_o,
  output logic [63:0] avail_o,
  output logic [63:0] used_o
);

  localparam logic [15:0] RST_SIZE = 16'(MAX_QSIZE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_o <= RST_SIZE; vec_o <= NO_VECTOR; en_o <= 1'b0;
      desc_o <= '0; avail_o <= '0; used_o <= '0;
    end else if (clr_i) begin
      size_o <= RST_SIZE; vec_o <= NO_VECTOR; en_o <= 1'b0;
      desc_o <= '0; avail_o <= '0; used_o <= '0;
    end else if (wr_i) begin
      case (fld_i)
        FLD_QSIZE:   if (size_ok(wdata_i[15:0], MAX_QSIZE)) size_o <= wdata_i[15:0];
        FLD_QVEC:    vec_o <= vec_map(wdata_i[31:16], VEC_TABLE);
        FLD_QEN:     en_o <= wdata_i[0];
        FLD_DESC_LO: desc_o[31:0]  <= wdata_i;
        FLD_DESC_HI: desc_o[63:32] <= wdata_i;
        FLD_AVL_LO:  avail_o[31:0]  <= wdata_i;
        FLD_AVL_HI:  avail_o[63:32] <= wdata_i;
        FLD_USED_LO: used_o[31:0]  <= wdata_i;
        FLD_USED_HI: used_o[63:32] <= wdata_i;
        default: ;
      endcase
    end
  end

  AST_QSIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    size_ok(size_o, MAX_QSIZE)); // R5
  AST_VEC_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ({16'd0, vec_o} < VEC_TABLE) || (vec_o == NO_VECTOR)); // R6
  AST_IDLE_SLOT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && !clr_i) |=> $stable({size_o, vec_o, en_o, desc_o, avail_o, used_o})); // R8

endmodule

// File: rtl/vq_cfg_regs.sv
module vq_cfg_regs
  import vq_cfg_pkg::*;
#(
  parameter int unsigned NUM_Q        = 4,
  parameter int unsigned MAX_QSIZE    = 256,
  parameter int unsigned VEC_TABLE    = 64,
  parameter logic [63:0] DEV_FEATURES = 64'hA5A5_0F0F_1234_8001,
  parameter int          ADDR_W       = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [3:0]            bus_be,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic                  bus_rvalid,
  output logic [63:0]           drv_feat_o,
  output logic [7:0]            dev_status_o,
  output logic [15:0]           cfg_vec_o,
  output logic [NUM_Q*16-1:0]   q_size_o,
  output logic [NUM_Q*16-1:0]   q_vec_o,
  output logic [NUM_Q-1:0]      q_en_o,
  output logic [NUM_Q-1:0]      q_active_o,
  output logic [NUM_Q*64-1:0]   q_desc_o,
  output logic [NUM_Q*64-1:0]   q_avail_o,
  output logic [NUM_Q*64-1:0]   q_used_o
);

  localparam int QIW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;

  fld_e        fld;
  logic [31:0] dfsel_q, gfsel_q;
  logic [15:0] qsel_q;
  logic [31:0] rd_word;

  // named events for the assertions
  logic wr_evt, q_in_range, status_clr_evt, gfeat_drop_evt, bad_access_wr;
  logic [QIW-1:0] qidx;

  logic [15:0] sz  [NUM_Q];
  logic [15:0] vec [NUM_Q];
  logic        en  [NUM_Q];
  logic [63:0] dsc [NUM_Q];
  logic [63:0] avl [NUM_Q];
  logic [63:0] usd [NUM_Q];

  vq_cfg_decode #(.ADDR_W(ADDR_W)) dec_i (
    .addr_i(bus_addr), .be_i(bus_be), .fld_o(fld)
  );

  assign wr_evt         = bus_wr && (fld != FLD_NONE);
  assign bad_access_wr  = bus_wr && (fld == FLD_NONE);
  assign q_in_range     = ({16'd0, qsel_q} < NUM_Q);
  assign qidx           = qsel_q[QIW-1:0];
  assign status_clr_evt = wr_evt && (fld == FLD_STATUS) && (bus_wdata[7:0] == 8'd0);
  assign gfeat_drop_evt = wr_evt && (fld == FLD_GFEAT) && (gfsel_q > 32'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dfsel_q <= '0; gfsel_q <= '0; drv_feat_o <= '0;
      cfg_vec_o <= NO_VECTOR; dev_status_o <= '0; qsel_q <= '0;
    end else if (wr_evt) begin
      case (fld)
        FLD_DFSEL:  dfsel_q <= bus_wdata;
        FLD_GFSEL:  gfsel_q <= bus_wdata;
        FLD_GFEAT:  if (gfsel_q == 32'd0) drv_feat_o[31:0] <= bus_wdata;
                    else if (gfsel_q == 32'd1) drv_feat_o[63:32] <= bus_wdata;
        FLD_CFGVEC: cfg_vec_o <= vec_map(bus_wdata[15:0], VEC_TABLE);
        FLD_STATUS: begin
          dev_status_o <= bus_wdata[7:0];
          if (bus_wdata[7:0] == 8'd0) begin
            dfsel_q <= '0; gfsel_q <= '0; qsel_q <= '0;
          end
        end
        FLD_QSEL:   qsel_q <= bus_wdata[31:16];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_Q; i++) begin : g_q
    logic slot_wr;
    assign slot_wr = wr_evt && is_queue_fld(fld) && (qsel_q == 16'(i));

    vq_cfg_qslot #(.MAX_QSIZE(MAX_QSIZE), .VEC_TABLE(VEC_TABLE)) slot_i (
      .clk(clk), .rst_n(rst_n), .clr_i(status_clr_evt), .wr_i(slot_wr),
      .fld_i(fld), .wdata_i(bus_wdata),
      .size_o(sz[i]), .vec_o(vec[i]), .en_o(en[i]),
      .desc_o(dsc[i]), .avail_o(avl[i]), .used_o(usd[i])
    );

    assign q_size_o[i*16 +: 16]  = sz[i];
    assign q_vec_o[i*16 +: 16]   = vec[i];
    assign q_en_o[i]             = en[i];
    assign q_active_o[i]         = en[i] && (sz[i] != 16'd0);
    assign q_desc_o[i*64 +: 64]  = dsc[i];
    assign q_avail_o[i*64 +: 64] = avl[i];
    assign q_used_o[i*64 +: 64]  = usd[i];
  end

  always_comb begin
    rd_word = '0;
    case (fld)
      FLD_DFSEL:  rd_word = dfsel_q;
      FLD_DFEAT:  rd_word = feat_window(DEV_FEATURES, dfsel_q);
      FLD_GFSEL:  rd_word = gfsel_q;
      FLD_GFEAT:  rd_word = feat_window(drv_feat_o, gfsel_q);
      FLD_CFGVEC: rd_word = {16'd0, cfg_vec_o};
      FLD_NUMQ:   rd_word = {16'(NUM_Q), 16'd0};
      FLD_STATUS: rd_word = {24'd0, dev_status_o};
      FLD_QSEL:   rd_word = {qsel_q, 16'd0};
      default:    rd_word = '0;
    endcase
    if (is_queue_fld(fld) && q_in_range) begin
      case (fld)
        FLD_QSIZE:   rd_word = {16'd0, sz[qidx]};
        FLD_QVEC:    rd_word = {vec[qidx], 16'd0};
        FLD_QEN:     rd_word = {31'd0, en[qidx]};
        FLD_QNOFF:   rd_word = {qsel_q, 16'd0};
        FLD_DESC_LO: rd_word = dsc[qidx][31:0];
        FLD_DESC_HI: rd_word = dsc[qidx][63:32];
        FLD_AVL_LO:  rd_word = avl[qidx][31:0];
        FLD_AVL_HI:  rd_word = avl[qidx][63:32];
        FLD_USED_LO: rd_word = usd[qidx][31:0];
        FLD_USED_HI: rd_word = usd[qidx][63:32];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0; bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      bus_rdata  <= bus_rd ? rd_word : 32'd0;
    end
  end

  AST_SOFT_RESET_SELECTS: assert property (@(posedge clk) disable iff (!rst_n)
    status_clr_evt |=> (dfsel_q == 32'd0 && gfsel_q == 32'd0 && qsel_q == 16'd0)); // R9
  AST_GFEAT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    gfeat_drop_evt |=> $stable(drv_feat_o)); // R3
  AST_BAD_ACCESS_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access_wr |=> $stable({dfsel_q, gfsel_q, drv_feat_o, cfg_vec_o, dev_status_o, qsel_q})); // R10
  AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid); // R13
  AST_RVALID_ONLY_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid); // R13

endmodule

// File: tb/vq_cfg_regs_tb_top.sv
`timescale 1ns/1ps
module vq_cfg_regs_tb_top;

  localparam int unsigned NQ   = 4;
  localparam int unsigned MAXQ = 256;
  localparam int unsigned VT   = 64;
  localparam logic [63:0] DEVF = 64'hA5A5_0F0F_1234_8001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [63:0] drv_feat_o;
  logic [7:0]  dev_status_o;
  logic [15:0] cfg_vec_o;
  logic [NQ*16-1:0] q_size_o, q_vec_o;
  logic [NQ-1:0]    q_en_o, q_active_o;
  logic [NQ*64-1:0] q_desc_o, q_avail_o, q_used_o;

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 1'b0;

  always #2.5 clk = ~clk;

  vq_cfg_regs #(.NUM_Q(NQ), .MAX_QSIZE(MAXQ), .VEC_TABLE(VT), .DEV_FEATURES(DEVF), .ADDR_W(6)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_be(bus_be), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .drv_feat_o(drv_feat_o), .dev_status_o(dev_status_o), .cfg_vec_o(cfg_vec_o),
    .q_size_o(q_size_o), .q_vec_o(q_vec_o), .q_en_o(q_en_o), .q_active_o(q_active_o),
    .q_desc_o(q_desc_o), .q_avail_o(q_avail_o), .q_used_o(q_used_o)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_dfsel, m_gfsel;
  logic [31:0] m_gfeat [2];
  logic [15:0] m_cfgvec, m_qsel;
  logic [7:0]  m_status;
  int          m_qsize [NQ];
  int          m_qvec  [NQ];
  bit          m_qen   [NQ];
  logic [63:0] m_desc [NQ], m_avail [NQ], m_used [NQ];

  task automatic m_clear_queues();
    for (int q = 0; q < NQ; q++) begin
      m_qsize[q] = MAXQ; m_qvec[q] = 'hFFFF; m_qen[q] = 0;
      m_desc[q] = 0; m_avail[q] = 0; m_used[q] = 0;
    end
  endtask

  task automatic m_reset();
    m_dfsel = 0; m_gfsel = 0; m_gfeat[0] = 0; m_gfeat[1] = 0;
    m_cfgvec = 16'hFFFF; m_status = 0; m_qsel = 0;
    m_clear_queues();
  endtask

  function automatic int vec_of(int v);
    return (v < VT) ? v : 'hFFFF;
  endfunction

  function automatic bit size_legal(int v);
    int p = 1;
    if (v == 0) return 1;
    while (p < v) p = p * 2;
    return (p == v) && (v <= MAXQ);
  endfunction

  function automatic logic [31:0] m_read(int addr, logic [3:0] be);
    int w = addr / 4;
    int q = m_qsel;
    bit qok = (q < NQ);
    if (addr % 4 != 0) return 0;
    if (w == 0 && be == 4'hF) return m_dfsel;
    if (w == 1 && be == 4'hF) return (m_dfsel == 0) ? DEVF[31:0] : (m_dfsel == 1) ? DEVF[63:32] : 32'd0;
    if (w == 2 && be == 4'hF) return m_gfsel;
    if (w == 3 && be == 4'hF) return (m_gfsel < 2) ? m_gfeat[m_gfsel] : 32'd0;
    if (w == 4 && be == 4'h3) return {16'd0, m_cfgvec};
    if (w == 4 && be == 4'hC) return NQ << 16;
    if (w == 5 && be == 4'h1) return {24'd0, m_status};
    if (w == 5 && be == 4'hC) return {m_qsel, 16'd0};
    if (!qok) return 0;
    if (w == 6 && be == 4'h3) return m_qsize[q];
    if (w == 6 && be == 4'hC) return m_qvec[q] << 16;
    if (w == 7 && be == 4'h3) return {31'd0, m_qen[q]};
    if (w == 7 && be == 4'hC) return q << 16;
    if (be != 4'hF) return 0;
    case (w)
      8:  return m_desc[q][31:0];
      9:  return m_desc[q][63:32];
      10: return m_avail[q][31:0];
      11: return m_avail[q][63:32];
      12: return m_used[q][31:0];
      13: return m_used[q][63:32];
      default: return 0;
    endcase
  endfunction

  task automatic m_write(int addr, logic [3:0] be, logic [31:0] d);
    int w = addr / 4;
    int q = m_qsel;
    if (addr % 4 != 0) return;
    if (w == 0 && be == 4'hF) m_dfsel = d;
    else if (w == 2 && be == 4'hF) m_gfsel = d;
    else if (w == 3 && be == 4'hF) begin if (m_gfsel < 2) m_gfeat[m_gfsel] = d; end
    else if (w == 4 && be == 4'h3) m_cfgvec = 16'(vec_of(int'(d[15:0])));
    else if (w == 5 && be == 4'h1) begin
      m_status = d[7:0];
      if (d[7:0] == 0) begin m_dfsel = 0; m_gfsel = 0; m_qsel = 0; m_clear_queues(); end
    end
    else if (w == 5 && be == 4'hC) m_qsel = d[31:16];
    else if (q < NQ) begin
      if (w == 6 && be == 4'h3) begin if (size_legal(int'(d[15:0]))) m_qsize[q] = d[15:0]; end
      else if (w == 6 && be == 4'hC) m_qvec[q] = vec_of(int'(d[31:16]));
      else if (w == 7 && be == 4'h3) m_qen[q] = d[0];
      else if (be == 4'hF) begin
        case (w)
          8:  m_desc[q][31:0] = d;
          9:  m_desc[q][63:32] = d;
          10: m_avail[q][31:0] = d;
          11: m_avail[q][63:32] = d;
          12: m_used[q][31:0] = d;
          13: m_used[q][63:32] = d;
          default: ;
        endcase
      end
    end
  endtask

  // ---------------- checking ----------------
  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // every-clock comparison of the core-facing outputs (R7 R11 R12 and others)
  always @(negedge clk) begin
    if (cmp_on) begin
      logic [NQ*16-1:0] es, ev;
      logic [NQ-1:0] ee, ea;
      logic [NQ*64-1:0] ed, eav, eu;
      bit ok;
      for (int q = 0; q < NQ; q++) begin
        es[q*16 +: 16] = 16'(m_qsize[q]);
        ev[q*16 +: 16] = 16'(m_qvec[q]);
        ee[q] = m_qen[q];
        ea[q] = m_qen[q] && (m_qsize[q] != 0);
        ed[q*64 +: 64] = m_desc[q];
        eav[q*64 +: 64] = m_avail[q];
        eu[q*64 +: 64] = m_used[q];
      end
      ok = (q_size_o == es) && (q_vec_o == ev) && (q_en_o == ee) && (q_desc_o == ed) &&
           (q_avail_o == eav) && (q_used_o == eu) && (cfg_vec_o == m_cfgvec) &&
           (dev_status_o == m_status) && (drv_feat_o == {m_gfeat[1], m_gfeat[0]});
      chk(ok, "R7/R12 core outputs", {q_size_o[31:0], q_vec_o[31:0]}, {es[31:0], ev[31:0]});
      chk(q_active_o == ea, "R11 active flag", 64'(q_active_o), 64'(ea));
    end
  end

  task automatic bwr(int addr, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    bus_addr = 6'(addr); bus_be = be; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
    m_write(addr, be, d);
  endtask

  task automatic brd(int addr, logic [3:0] be, logic [31:0] exp, string req);
    @(negedge clk);
    bus_addr = 6'(addr); bus_be = be; bus_rd = 1'b1;
    @(posedge clk);
    #1 bus_rd = 1'b0;
    @(negedge clk);
    chk(bus_rvalid && (bus_rdata == exp), req, {31'd0, bus_rvalid, bus_rdata}, {32'd1, exp});
  endtask

  task automatic bchk(int addr, logic [3:0] be, string req);
    brd(addr, be, m_read(addr, be), req);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cmp_on = 1'b1;

    // R1 reset values, literal expectations
    brd(20, 4'h1, 32'h0, "R1 status reset");
    brd(24, 4'h3, MAXQ, "R1 queue size reset");
    brd(24, 4'hC, 32'hFFFF_0000, "R1 queue vector reset");
    brd(16, 4'h3, 32'h0000_FFFF, "R1 config vector reset");
    brd(16, 4'hC, NQ << 16, "R1 queue count");
    brd(0, 4'hF, 32'h0, "R1 feature select reset");

    // R2 offered feature window
    brd(4, 4'hF, DEVF[31:0], "R2 select 0");
    bwr(0, 4'hF, 1);
    brd(4, 4'hF, DEVF[63:32], "R2 select 1");
    bwr(0, 4'hF, 7);
    brd(4, 4'hF, 32'h0, "R2 select out of range");

    // R3 acknowledged feature window
    bwr(12, 4'hF, 32'hDEAD_BEEF);
    bwr(8, 4'hF, 1);
    bwr(12, 4'hF, 32'h0000_0011);
    bwr(8, 4'hF, 5);
    bwr(12, 4'hF, 32'hFFFF_FFFF);
    brd(12, 4'hF, 32'h0, "R3 read with bad select");
    chk(drv_feat_o == 64'h0000_0011_DEAD_BEEF, "R3 drop write", drv_feat_o, 64'h0000_0011_DEAD_BEEF);
    bwr(8, 4'hF, 0);
    brd(12, 4'hF, 32'hDEAD_BEEF, "R3 low word");

    // R4 read-only fields
    bwr(0, 4'hF, 0);
    bwr(4, 4'hF, 32'h1111_1111);
    brd(4, 4'hF, DEVF[31:0], "R4 offered features unchanged");
    bwr(16, 4'hC, 32'h0009_0000);
    brd(16, 4'hC, NQ << 16, "R4 queue count unchanged");
    bwr(22 - 2, 4'hC, 32'h0002_0000);
    bwr(28, 4'hC, 32'h0033_0000);
    brd(28, 4'hC, 32'h0002_0000, "R4 notify offset is index");

    // R5 queue size on queue 2
    bwr(24, 4'h3, 64);
    bchk(24, 4'h3, "R5 legal size");
    bwr(24, 4'h3, 100);
    brd(24, 4'h3, 64, "R5 non power of two kept");
    bwr(24, 4'h3, 512);
    brd(24, 4'h3, 64, "R5 above max kept");
    bwr(24, 4'h3, 0);
    brd(24, 4'h3, 0, "R5 zero accepted");

    // R6 vectors
    bwr(16, 4'h3, 63);
    brd(16, 4'h3, 63, "R6 config vector in table");
    bwr(16, 4'h3, 64);
    brd(16, 4'h3, 32'h0000_FFFF, "R6 config vector beyond table");
    bwr(24, 4'hC, 32'h07FF_0000);
    brd(24, 4'hC, 32'hFFFF_0000, "R6 queue vector beyond table");
    bwr(24, 4'hC, 32'h000A_0000);
    brd(24, 4'hC, 32'h000A_0000, "R6 queue vector kept");

    // R7 R12 banking and 64-bit halves
    bwr(20, 4'hC, 32'h0001_0000);
    bwr(28, 4'h3, 1);
    bwr(32, 4'hF, 32'h8765_4321);
    bwr(36, 4'hF, 32'h0000_00AB);
    bwr(40, 4'hF, 32'h1000);
    bwr(52, 4'hF, 32'h22);
    chk(q_desc_o[64 +: 64] == 64'h0000_00AB_8765_4321, "R12 descriptor halves",
        q_desc_o[64 +: 64], 64'h0000_00AB_8765_4321);
    chk(q_active_o[1] == 1'b1, "R11 enabled nonzero size", 64'(q_active_o), 64'h2);
    bwr(20, 4'hC, 32'h0003_0000);
    bwr(32, 4'hF, 32'h5555_5555);
    bwr(20, 4'hC, 32'h0001_0000);
    brd(32, 4'hF, 32'h8765_4321, "R7 queue 1 untouched by queue 3");
    brd(36, 4'hF, 32'h0000_00AB, "R12 descriptor high half");
    bchk(52, 4'hF, "R12 used high half");
    bwr(24, 4'h3, 0);
    chk(q_active_o[1] == 1'b0, "R11 zero size inactive", 64'(q_active_o), 64'h0);

    // R8 selector out of range
    bwr(20, 4'hC, 32'h0009_0000);
    brd(24, 4'h3, 0, "R8 size reads 0");
    bwr(24, 4'h3, 16);
    bwr(28, 4'h3, 1);
    brd(28, 4'h3, 0, "R8 enable reads 0");
    brd(28, 4'hC, 0, "R8 notify offset reads 0");

    // R10 malformed and unmapped accesses
    bwr(20, 4'hC, 32'h0000_0000);
    bwr(56, 4'hF, 32'hFFFF_FFFF);
    bwr(0, 4'h3, 32'h0000_0001);
    brd(0, 4'hF, 0, "R10 partial-width write ignored");
    bwr(26, 4'hC, 32'h0003_0000);
    brd(26, 4'hC, 0, "R10 unaligned read");
    bwr(20, 4'h2, 32'h0000_5500);
    brd(20, 4'h2, 0, "R10 reserved byte");
    brd(0, 4'h1, 0, "R10 narrow read of 32-bit field");
    brd(20, 4'hC, 0, "R10 queue select unchanged");

    // R9 status behaviour and soft reset
    bwr(20, 4'h1, 32'h0F);
    chk(dev_status_o == 8'h0F, "R9 status stored", 64'(dev_status_o), 64'h0F);
    bwr(0, 4'hF, 1);
    bwr(8, 4'hF, 1);
    bwr(20, 4'hC, 32'h0002_0000);
    bwr(20, 4'h1, 32'h00);
    brd(0, 4'hF, 0, "R9 offered select cleared");
    brd(8, 4'hF, 0, "R9 driver select cleared");
    brd(20, 4'hC, 0, "R9 queue select cleared");
    chk(q_size_o[16 +: 16] == 16'(MAXQ) && q_en_o == '0 && q_desc_o == '0, "R9 queues restored",
        {q_size_o[16 +: 16], 44'd0, q_en_o}, {16'(MAXQ), 48'd0});

    // R13 valid lasts one cycle
    brd(16, 4'hC, NQ << 16, "R13 read data");
    @(negedge clk);
    chk(bus_rvalid == 1'b0 && bus_rdata == 32'd0, "R13 valid single cycle", {31'd0, bus_rvalid, bus_rdata}, 64'd0);

    repeat (2) @(negedge clk);
    cmp_on = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule